// File: doc/BRIEF.md
# PC Sample Profiling Register Unit

This unit keeps the most recent instruction address sampled from a processor trace port. It also keeps the security state, the privilege level and the context and VMID tags that go with that address. An external debugger reads all of it through a 32-bit read-only register window. Reading the low address word is the trigger. In one action it returns the low word and freezes the matching upper word and companion tags into shadow registers. Later reads of those registers then describe the same sample as the low word.

Some conditions make the read return the all-ones marker word 0xFFFFFFFF instead of an address:

- the processor is halted for debug;
- profiling is forbidden;
- nothing has been sampled since the processor last left reset, halt or the forbidden state.

Other behaviour at the read interface:

- A software lock turns the trigger read into a plain read of the held value.
- Any mapped access is refused with an error response unless three conditions hold: the core is powered, the double lock is clear and the OS lock is clear.
- An optional wide read returns the fresh low word and its upper word together in one response.

Register state is cleared only by the block reset `rst`, which stands for cold reset. The processor-reset input `core_reset` only marks that no sample is pending. Unknown values are modelled as zero.

Top module: `pc_sample_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `rd_valid` and `rd_err` are 0 after that edge. After reset, every shadow register reads 0.
- R2: A permitted, unlocked read at word offset 0x80 returns the sampled address bits 31:0. A later read at word offset 0x81 returns the upper word of that sample. Its layout is: bit 31 holds the non-secure flag, bits 30:29 hold the exception level (0 to 3), bits 28:24 read 0, and bits 23:0 hold address bits 55:32.
- R3: Word offsets 0x88 and 0x89 behave exactly like 0x80 and 0x81.
- R4: The trigger read also captures the companion tags. They are readable at word offsets 0x82 (context ID 1), 0x83 (context ID 2) and 0x84 (VMID, zero-extended).
- R5: While `sw_lock` is 1, a low-word read returns the held low word and leaves the upper word and the tags unchanged.
- R6: While `core_debug` or `prof_prohibit` is 1, a low-word read returns 0xFFFFFFFF and clears the upper word and the tags to 0.
- R7: A low-word read returns 0xFFFFFFFF if no sample strobe has arrived since `core_reset`, `core_debug` or `prof_prohibit` was last high. After a strobe arrives, it returns the address again.
- R8: A mapped access is refused if `core_powered` is 0, `double_lock` is 1 or `os_lock` is 1. A refused access returns `rd_err`=1 with data 0 and changes no state.
- R9: A read with `rd_wide`=1 at a low-word offset returns {upper word, low word} in one response and has the same side effects as a low-word read.
- R10: A read at an unmapped offset returns `rd_valid`=1 with `rd_err`=0 and data 0, and changes no state.
- R11: Each request is answered exactly one clock later with `rd_valid` high for one cycle. There is no response without a request.
- R12: A pulse on `core_reset` leaves the shadow registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous cold reset, active high |
| smp_valid | input | 1 | Sample strobe from the trace port |
| smp_pc | input | PC_W | Sampled instruction address |
| smp_ns | input | 1 | Non-secure flag of the sample |
| smp_el | input | 2 | Exception level of the sample |
| smp_ctx1 | input | CTX_W | Context ID 1 of the sample |
| smp_ctx2 | input | CTX_W | Context ID 2 of the sample |
| smp_vmid | input | VMID_W | VMID of the sample |
| core_reset | input | 1 | Processor is held in reset |
| core_debug | input | 1 | Processor is halted for debug |
| prof_prohibit | input | 1 | Profiling is forbidden |
| sw_lock | input | 1 | Software lock engaged |
| core_powered | input | 1 | Core power domain is on |
| double_lock | input | 1 | Double lock set |
| os_lock | input | 1 | OS lock set |
| rd_req | input | 1 | Read request, one cycle |
| rd_off | input | OFF_W | Word offset of the read |
| rd_wide | input | 1 | Request a 64-bit atomic read |
| rd_valid | output | 1 | Response valid |
| rd_err | output | 1 | Error response |
| rd_data | output | 64 | Read data; bits 63:32 are 0 unless the read is wide |

## Verification
The bench uses the default widths: a 56-bit address, 32-bit context IDs and a 16-bit VMID. With these widths the upper word packs exactly into 32 bits, so every field boundary of R2 is checked, including the reserved gap. A zero-extended VMID lets the bench see stray upper bits in the tag read. The sample values are chosen so that every upper-word field holds a value distinct from its neighbours. This makes a swapped or shifted field visible in a single read.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [7:0] OFF_LO_A = 8'h80;
  localparam logic [7:0] OFF_HI_A = 8'h81;
  localparam logic [7:0] OFF_LO_B = 8'h88;
  localparam logic [7:0] OFF_HI_B = 8'h89;
  localparam logic [7:0] OFF_CTX1 = 8'h82;
  localparam logic [7:0] OFF_CTX2 = 8'h83;
  localparam logic [7:0] OFF_VMID = 8'h84;
  localparam logic [31:0] MARKER  = 32'hFFFF_FFFF;

  typedef struct packed {
    logic is_lo;
    logic is_hi;
    logic is_ctx1;
    logic is_ctx2;
    logic is_vmid;
  } pcs_hit_t;
endpackage

// File: rtl/pcs_capture.sv
module pcs_capture #(
  parameter int PC_W   = 56,
  parameter int CTX_W  = 32,
  parameter int VMID_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              excluded,
  input  logic              smp_valid,
  input  logic [PC_W-1:0]   smp_pc,
  input  logic              smp_ns,
  input  logic [1:0]        smp_el,
  input  logic [CTX_W-1:0]  smp_ctx1,
  input  logic [CTX_W-1:0]  smp_ctx2,
  input  logic [VMID_W-1:0] smp_vmid,
  output logic [PC_W-1:0]   live_pc,
  output logic              live_ns,
  output logic [1:0]        live_el,
  output logic [CTX_W-1:0]  live_ctx1,
  output logic [CTX_W-1:0]  live_ctx2,
  output logic [VMID_W-1:0] live_vmid,
  output logic              seen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live_pc   <= '0;
      live_ns   <= 1'b0;
      live_el   <= '0;
      live_ctx1 <= '0;
      live_ctx2 <= '0;
      live_vmid <= '0;
      seen      <= 1'b0;
    end else if (excluded) begin
      seen <= 1'b0;
    end else if (smp_valid) begin
      live_pc   <= smp_pc;
      live_ns   <= smp_ns;
      live_el   <= smp_el;
      live_ctx1 <= smp_ctx1;
      live_ctx2 <= smp_ctx2;
      live_vmid <= smp_vmid;
      seen      <= 1'b1;
    end
  end
endmodule

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic [OFF_W-1:0] off,
  input  logic             core_powered,
  input  logic             double_lock,
  input  logic             os_lock,
  output pcs_hit_t         hit,
  output logic             mapped,
  output logic             perm_ok
);
  localparam logic [OFF_W-1:0] LO_A = OFF_W'(OFF_LO_A);
  localparam logic [OFF_W-1:0] LO_B = OFF_W'(OFF_LO_B);
  localparam logic [OFF_W-1:0] HI_A = OFF_W'(OFF_HI_A);
  localparam logic [OFF_W-1:0] HI_B = OFF_W'(OFF_HI_B);

  always_comb begin
    hit.is_lo   = (off == LO_A) || (off == LO_B);
    hit.is_hi   = (off == HI_A) || (off == HI_B);
    hit.is_ctx1 = (off == OFF_W'(OFF_CTX1));
    hit.is_ctx2 = (off == OFF_W'(OFF_CTX2));
    hit.is_vmid = (off == OFF_W'(OFF_VMID));
    mapped      = |hit;
    perm_ok     = core_powered && !double_lock && !os_lock;
  end
endmodule

// File: rtl/pcs_snapshot.sv
module pcs_snapshot (
  input  logic        clk,
  input  logic        rst,
  input  logic        capture,
  input  logic [31:0] nxt_lo,
  input  logic [31:0] nxt_hi,
  input  logic [31:0] nxt_ctx1,
  input  logic [31:0] nxt_ctx2,
  input  logic [31:0] nxt_vmid,
  output logic [31:0] snap_lo,
  output logic [31:0] snap_hi,
  output logic [31:0] snap_ctx1,
  output logic [31:0] snap_ctx2,
  output logic [31:0] snap_vmid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_lo   <= '0;
      snap_hi   <= '0;
      snap_ctx1 <= '0;
      snap_ctx2 <= '0;
      snap_vmid <= '0;
    end else if (capture) begin
      snap_lo   <= nxt_lo;
      snap_hi   <= nxt_hi;
      snap_ctx1 <= nxt_ctx1;
      snap_ctx2 <= nxt_ctx2;
      snap_vmid <= nxt_vmid;
    end
  end
endmodule

// File: rtl/pc_sample_unit.sv
module pc_sample_unit
  import pcs_pkg::*;
#(
  parameter int PC_W   = 56,
  parameter int CTX_W  = 32,
  parameter int VMID_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [PC_W-1:0]   smp_pc,
  input  logic              smp_ns,
  input  logic [1:0]        smp_el,
  input  logic [CTX_W-1:0]  smp_ctx1,
  input  logic [CTX_W-1:0]  smp_ctx2,
  input  logic [VMID_W-1:0] smp_vmid,
  input  logic              core_reset,
  input  logic              core_debug,
  input  logic              prof_prohibit,
  input  logic              sw_lock,
  input  logic              core_powered,
  input  logic              double_lock,
  input  logic              os_lock,
  input  logic              rd_req,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              rd_wide,
  output logic              rd_valid,
  output logic              rd_err,
  output logic [63:0]       rd_data
);
  localparam int UPPER_W = PC_W - 32;
  localparam int RES_W   = 32 - 3 - UPPER_W;

  logic [PC_W-1:0]   live_pc;
  logic              live_ns;
  logic [1:0]        live_el;
  logic [CTX_W-1:0]  live_ctx1, live_ctx2;
  logic [VMID_W-1:0] live_vmid;
  logic              seen, excluded, sentinel, trigger, mapped, perm_ok;
  pcs_hit_t          hit;
  logic [31:0] nxt_lo, nxt_hi, nxt_ctx1, nxt_ctx2, nxt_vmid;
  logic [31:0] snap_lo, snap_hi, snap_ctx1, snap_ctx2, snap_vmid;
  logic [63:0] resp_data;

  assign excluded = core_reset || core_debug || prof_prohibit;

  pcs_capture #(.PC_W(PC_W), .CTX_W(CTX_W), .VMID_W(VMID_W)) u_capture (
    .clk(clk), .rst(rst), .excluded(excluded), .smp_valid(smp_valid),
    .smp_pc(smp_pc), .smp_ns(smp_ns), .smp_el(smp_el),
    .smp_ctx1(smp_ctx1), .smp_ctx2(smp_ctx2), .smp_vmid(smp_vmid),
    .live_pc(live_pc), .live_ns(live_ns), .live_el(live_el),
    .live_ctx1(live_ctx1), .live_ctx2(live_ctx2), .live_vmid(live_vmid),
    .seen(seen)
  );

  pcs_decode #(.OFF_W(OFF_W)) u_decode (
    .off(rd_off), .core_powered(core_powered), .double_lock(double_lock),
    .os_lock(os_lock), .hit(hit), .mapped(mapped), .perm_ok(perm_ok)
  );

  assign sentinel = excluded || !seen;
  assign trigger  = rd_req && hit.is_lo && perm_ok && !sw_lock;

  always_comb begin
    if (sentinel) begin
      nxt_lo   = MARKER;
      nxt_hi   = '0;
      nxt_ctx1 = '0;
      nxt_ctx2 = '0;
      nxt_vmid = '0;
    end else begin
      nxt_lo   = live_pc[31:0];
      nxt_hi   = {live_ns, live_el, {RES_W{1'b0}}, live_pc[PC_W-1:32]};
      nxt_ctx1 = 32'(live_ctx1);
      nxt_ctx2 = 32'(live_ctx2);
      nxt_vmid = 32'(live_vmid);
    end
  end

  pcs_snapshot u_snapshot (
    .clk(clk), .rst(rst), .capture(trigger),
    .nxt_lo(nxt_lo), .nxt_hi(nxt_hi), .nxt_ctx1(nxt_ctx1),
    .nxt_ctx2(nxt_ctx2), .nxt_vmid(nxt_vmid),
    .snap_lo(snap_lo), .snap_hi(snap_hi), .snap_ctx1(snap_ctx1),
    .snap_ctx2(snap_ctx2), .snap_vmid(snap_vmid)
  );

  always_comb begin
    resp_data = '0;
    if (mapped && perm_ok) begin
      if (hit.is_lo) begin
        if (sw_lock) resp_data = rd_wide ? {snap_hi, snap_lo} : {32'd0, snap_lo};
        else         resp_data = rd_wide ? {nxt_hi, nxt_lo}   : {32'd0, nxt_lo};
      end else if (hit.is_hi)   resp_data = {32'd0, snap_hi};
      else if (hit.is_ctx1)     resp_data = {32'd0, snap_ctx1};
      else if (hit.is_ctx2)     resp_data = {32'd0, snap_ctx2};
      else                      resp_data = {32'd0, snap_vmid};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_err   <= rd_req && mapped && !perm_ok;
      rd_data  <= rd_req ? resp_data : '0;
    end
  end
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req,
  input logic [OFF_W-1:0] rd_off,
  input logic             rd_valid,
  input logic             rd_err,
  input logic [63:0]      rd_data,
  input logic             sw_lock,
  input logic             core_debug,
  input logic             prof_prohibit,
  input logic             core_powered,
  input logic             double_lock,
  input logic             os_lock,
  input logic [31:0]      snap_hi
);
  logic lo_off, hi_off, allowed;
  assign lo_off  = (rd_off == OFF_W'(8'h80)) || (rd_off == OFF_W'(8'h88));
  assign hi_off  = (rd_off == OFF_W'(8'h81)) || (rd_off == OFF_W'(8'h89));
  assign allowed = core_powered && !double_lock && !os_lock;

  p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  p_no_spurious_resp_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  p_err_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_valid && rd_data == 64'd0));
  p_denied_errors_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (lo_off || hi_off) && !allowed) |=> rd_err);
  p_marker_when_halted_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && lo_off && allowed && !sw_lock && (core_debug || prof_prohibit))
      |=> rd_data[31:0] == 32'hFFFF_FFFF);
  p_lock_keeps_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && sw_lock) |=> $stable(snap_hi));
endmodule

bind pc_sample_unit pcs_checker #(.OFF_W(OFF_W)) u_pcs_checker (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_off(rd_off),
  .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
  .sw_lock(sw_lock), .core_debug(core_debug), .prof_prohibit(prof_prohibit),
  .core_powered(core_powered), .double_lock(double_lock), .os_lock(os_lock),
  .snap_hi(snap_hi)
);

// File: tb/tb_pc_sample_unit.sv
module tb_pc_sample_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [55:0] smp_pc = '0;
  logic smp_ns = 1'b0;
  logic [1:0] smp_el = '0;
  logic [31:0] smp_ctx1 = '0, smp_ctx2 = '0;
  logic [15:0] smp_vmid = '0;
  logic core_reset = 1'b0, core_debug = 1'b0, prof_prohibit = 1'b0;
  logic sw_lock = 1'b0, core_powered = 1'b1, double_lock = 1'b0, os_lock = 1'b0;
  logic rd_req = 1'b0, rd_wide = 1'b0;
  logic [7:0] rd_off = '0;
  logic rd_valid, rd_err;
  logic [63:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [63:0] got;
  logic got_err, got_valid;

  always #10 clk = ~clk;

  pc_sample_unit dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_pc(smp_pc),
    .smp_ns(smp_ns), .smp_el(smp_el), .smp_ctx1(smp_ctx1),
    .smp_ctx2(smp_ctx2), .smp_vmid(smp_vmid), .core_reset(core_reset),
    .core_debug(core_debug), .prof_prohibit(prof_prohibit),
    .sw_lock(sw_lock), .core_powered(core_powered),
    .double_lock(double_lock), .os_lock(os_lock), .rd_req(rd_req),
    .rd_off(rd_off), .rd_wide(rd_wide), .rd_valid(rd_valid),
    .rd_err(rd_err), .rd_data(rd_data)
  );

  // word offset in bits 39:32, expected 32-bit data below it
  // R2, R3, R4 and R10 are walked here; all reads permitted and unlocked
  localparam logic [39:0] TABLE [10] = '{
    {8'h81, 32'h0000_0000},  // upper word still at reset value
    {8'h80, 32'h89AB_CDEF},  // R2 trigger
    {8'h81, 32'hC012_3456},  // R2 ns=1 el=2 addr[55:32]
    {8'h82, 32'hC1C1_0001},  // R4 ctx1
    {8'h83, 32'hC2C2_0002},  // R4 ctx2
    {8'h84, 32'h0000_00A5},  // R4 vmid zero-extended
    {8'h88, 32'h89AB_CDEF},  // R3 alias low
    {8'h10, 32'h0000_0000},  // R10 unmapped
    {8'h85, 32'h0000_0000},  // R10 unmapped next to tags
    {8'h89, 32'hC012_3456}   // R3 alias high, unchanged by R10 reads
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] off, input logic wide);
    @(negedge clk);
    rd_req = 1'b1; rd_off = off; rd_wide = wide;
    @(negedge clk);
    rd_req = 1'b0; rd_wide = 1'b0;
    got = rd_data; got_err = rd_err; got_valid = rd_valid;
  endtask

  task automatic strobe(input logic [55:0] pc, input logic ns, input logic [1:0] el,
                        input logic [31:0] c1, input logic [31:0] c2, input logic [15:0] vm);
    @(negedge clk);
    smp_valid = 1'b1; smp_pc = pc; smp_ns = ns; smp_el = el;
    smp_ctx1 = c1; smp_ctx2 = c2; smp_vmid = vm;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, rd_valid}, 64'd0);
    check("R1 err in reset",   {63'd0, rd_err},   64'd0);
    rst = 1'b0;
    @(negedge clk);

    strobe(56'h12_3456_89AB_CDEF, 1'b1, 2'd2, 32'hC1C1_0001, 32'hC2C2_0002, 16'h00A5);
    for (int i = 0; i < 10; i++) begin
      do_read(TABLE[i][39:32], 1'b0);
      check($sformatf("R2/R3/R4/R10 table[%0d] data", i), got, {32'd0, TABLE[i][31:0]});
      check($sformatf("R11 table[%0d] valid/err", i), {62'd0, got_valid, got_err}, 64'd2);
    end
    @(negedge clk);
    check("R11 single-cycle valid", {63'd0, rd_valid}, 64'd0);

    // R9 wide read
    strobe(56'hFE_DCBA_0000_4444, 1'b0, 2'd1, 32'h1, 32'h2, 16'h3);
    do_read(8'h80, 1'b1);
    check("R9 wide data", got, 64'h20FE_DCBA_0000_4444);

    // R5 lock
    sw_lock = 1'b1;
    strobe(56'h77_7777_7777_7777, 1'b0, 2'd0, 32'h5, 32'h6, 16'h7);
    do_read(8'h80, 1'b0);
    check("R5 locked low holds", got, 64'h0000_4444);
    do_read(8'h81, 1'b0);
    check("R5 locked high holds", got, 64'h20FE_DCBA);
    do_read(8'h82, 1'b0);
    check("R5 locked ctx1 holds", got, 64'h1);
    sw_lock = 1'b0;
    do_read(8'h80, 1'b0);
    check("R5 unlocked low fresh", got, 64'h7777_7777);
    do_read(8'h81, 1'b0);
    check("R5 unlocked high fresh", got, 64'h0077_7777);

    // R6 debug and prohibited
    core_debug = 1'b1;
    do_read(8'h80, 1'b0);
    check("R6 debug marker", got, 64'hFFFF_FFFF);
    do_read(8'h81, 1'b0);
    check("R6 debug high cleared", got, 64'h0);
    do_read(8'h83, 1'b0);
    check("R6 debug ctx2 cleared", got, 64'h0);
    core_debug = 1'b0;
    prof_prohibit = 1'b1;
    do_read(8'h88, 1'b0);
    check("R6 prohibit marker", got, 64'hFFFF_FFFF);
    prof_prohibit = 1'b0;

    // R7 nothing sampled since leaving excluded state
    do_read(8'h80, 1'b0);
    check("R7 no sample yet", got, 64'hFFFF_FFFF);
    strobe(56'h01_0203_0405_0607, 1'b1, 2'd3, 32'h8, 32'h9, 16'hA);
    do_read(8'h80, 1'b0);
    check("R7 sample after exit", got, 64'h0405_0607);

    // R12 processor reset keeps shadows
    @(negedge clk); core_reset = 1'b1;
    repeat (2) @(negedge clk); core_reset = 1'b0;
    do_read(8'h81, 1'b0);
    check("R12 high kept over core reset", got, 64'hE001_0203);
    do_read(8'h80, 1'b0);
    check("R7 marker after core reset", got, 64'hFFFF_FFFF);

    // R8 access refusal
    strobe(56'h01_0203_0405_0607, 1'b1, 2'd3, 32'h8, 32'h9, 16'hA);
    do_read(8'h80, 1'b0);
    check("R8 setup low", got, 64'h0405_0607);
    os_lock = 1'b1;
    strobe(56'h99_9999_9999_9999, 1'b1, 2'd1, 32'hB, 32'hC, 16'hD);
    do_read(8'h80, 1'b0);
    check("R8 os lock err", {got[63:1], got_err}, 64'd1);
    os_lock = 1'b0;
    do_read(8'h81, 1'b0);
    check("R8 refused read left high", got, 64'hE001_0203);
    core_powered = 1'b0;
    do_read(8'h81, 1'b0);
    check("R8 unpowered err", {got[63:1], got_err}, 64'd1);
    core_powered = 1'b1; double_lock = 1'b1;
    do_read(8'h82, 1'b0);
    check("R8 double lock err", {got[63:1], got_err}, 64'd1);
    double_lock = 1'b0;

    // R1 cold reset clears shadows
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_read(8'h81, 1'b0);
    check("R1 high after cold reset", got, 64'h0);

    finish_run();
  end
endmodule